// File: doc/BRIEF.md
# Fault Status and Alert Aggregator

This block keeps the sticky fault and warning bits of a two-channel digitally managed power converter and drives one shared active-low alert line. The voltage, current, temperature, input-supply and command-handling monitors send single-cycle event pulses. Each pulse sets a bit in one of five category status bytes. The output-voltage, output-current and temperature bytes exist once per channel. The input-supply byte and the communication byte are shared by both channels. A summary byte and the upper byte of a summary word are rebuilt every cycle as ORs of the category bytes. They are never stored on their own.

A simple register port carries the software accesses. The page input selects the channel for per-channel registers. Shared registers answer on every page. Writing a 1 to a status bit clears that bit and leaves the others alone. Writing to a mask register stops a bit from driving the alert, but the bit still latches. A separate clear-all strobe wipes every sticky bit at once and leaves the masks as they are. The alert stays asserted until software clears the bits that caused it, even after the fault itself has gone away.

Top module: `fault_alert_agg`

## Requirements
- R1: An event pulse on a supported bit sets that status bit in the following clock cycle. Supported positions are: output voltage 7 over-fault, 6 over-warn, 5 under-warn, 4 under-fault, 2 turn-on timeout; output current 7 over-fault, 5 over-warn; input 7 over-fault, 5 under-warn, 4 under-fault; temperature 7 over-fault, 6 over-warn, 5 under-warn, 4 under-fault; communication 7 bad command, 6 bad data, 5 checksum error, 0 busy.
- R2: `alert_n` is 0 whenever any sticky status bit is set and not masked, and 1 otherwise. The live off bit never drives it.
- R3: A set status bit stays set until a write-one-to-clear access or a clear-all strobe removes it, whatever its event input does in the meantime.
- R4: A register write with data D to a status address clears exactly the bits where D is 1. Bits where D is 0 are unchanged. Addresses: 2 output voltage, 3 output current, 4 input, 5 temperature, 6 communication.
- R5: A one-cycle `clr_all` pulse clears every sticky bit of both channels and the shared bytes. It leaves the mask registers unchanged.
- R6: Mask registers sit at the status address plus 8 (10 to 14). A masked bit still latches and reads back as 1, but it does not pull `alert_n` low.
- R7: The summary byte at address 0 has: bit 7 = busy, bit 6 = off, bit 5 = output over-voltage fault, bit 4 = output over-current fault, bit 3 = input under-voltage fault, bit 2 = any temperature bit, bit 1 = any communication bit other than busy, bit 0 = 0.
- R8: The summary word upper byte at address 1 has: bit 7 = any output-voltage bit, bit 6 = any output-current bit, bit 5 = any input bit. Its other bits are 0.
- R9: The off bit is the inverse of the channel's `ch_pwr_on` input in the same cycle. It is not sticky.
- R10: Unsupported bit positions of status and mask registers always read 0. Unused addresses read 0.
- R11: If an event and a clear (write-one-to-clear or clear-all) hit the same bit in the same cycle, the bit ends up set.
- R12: Per-channel registers are read and cleared only on the page that selects their channel. The input and communication bytes are the same on every page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ch_ev_vout | input | 16 | Output-voltage event pulses, byte c belongs to channel c |
| ch_ev_iout | input | 16 | Output-current event pulses per channel |
| ch_ev_temp | input | 16 | Temperature event pulses per channel |
| in_ev | input | 8 | Input-supply event pulses, shared |
| comm_ev | input | 8 | Communication and busy event pulses, shared |
| ch_pwr_on | input | 2 | Channel c is delivering power |
| clr_all | input | 1 | Clear every sticky bit |
| reg_wr | input | 1 | Register write strobe |
| reg_page | input | 1 | Channel select |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for page and address, combinational |
| alert_n | output | 1 | Shared alert, active low |

## Verification
The interesting collision is an event pulse arriving on the same bit, in the same cycle, as the clear that would remove it. The bench provokes this twice: once with a write-one-to-clear on that bit and once with the clear-all strobe, each paired with an event on the same position. It judges the outcome by reading the status byte back one cycle later and expecting the bit to be set. A second collision sets a masked bit together with an unmasked one. Clearing only the unmasked bit must release `alert_n` while the masked bit still reads back as set.

// File: rtl/fault_alert_pkg.sv
package fault_alert_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    CAT_SUM_BYTE = 3'd0,
    CAT_SUM_WORD = 3'd1,
    CAT_VOUT     = 3'd2,
    CAT_IOUT     = 3'd3,
    CAT_INPUT    = 3'd4,
    CAT_TEMP     = 3'd5,
    CAT_COMM     = 3'd6
  } cat_e;

  // implemented bit positions of each category byte
  localparam logic [BYTE_W-1:0] SUP_VOUT  = 8'hF4;
  localparam logic [BYTE_W-1:0] SUP_IOUT  = 8'hA0;
  localparam logic [BYTE_W-1:0] SUP_INPUT = 8'hB0;
  localparam logic [BYTE_W-1:0] SUP_TEMP  = 8'hF0;
  localparam logic [BYTE_W-1:0] SUP_COMM  = 8'hE1;
endpackage

// File: rtl/fab_rst_sync.sv
module fab_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_q_n <= stage_q;
    end
  end
endmodule

// File: rtl/fab_sticky_byte.sv
module fab_sticky_byte #(
  parameter int               W         = 8,
  parameter logic [W-1:0]     SUPPORTED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  input  logic         clr_all,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  output logic [W-1:0] stat,
  output logic [W-1:0] mask
);
  logic [W-1:0] stat_q, stat_d, clr_vec;
  logic [W-1:0] mask_q, mask_d;

  always_comb begin
    clr_vec = '0;
    if (clr_we)  clr_vec = clr_bits;
    if (clr_all) clr_vec = '1;
    // new events are ORed after the clear so they are never lost
    stat_d  = ((stat_q & ~clr_vec) | evt) & SUPPORTED;
    mask_d  = mask_wdata & SUPPORTED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  assign stat = stat_q;
  assign mask = mask_q;
endmodule

// File: rtl/fab_summary.sv
module fab_summary (
  input  logic [7:0] vout_st,
  input  logic [7:0] iout_st,
  input  logic [7:0] temp_st,
  input  logic [7:0] input_st,
  input  logic [7:0] comm_st,
  input  logic       pwr_on,
  output logic [7:0] sum_byte,
  output logic [7:0] sum_word_hi
);
  always_comb begin
    sum_byte    = '0;
    sum_byte[7] = comm_st[0];
    sum_byte[6] = ~pwr_on;
    sum_byte[5] = vout_st[7];
    sum_byte[4] = iout_st[7];
    sum_byte[3] = input_st[4];
    sum_byte[2] = |temp_st;
    sum_byte[1] = |comm_st[7:1];

    sum_word_hi    = '0;
    sum_word_hi[7] = |vout_st;
    sum_word_hi[6] = |iout_st;
    sum_word_hi[5] = |input_st;
  end
endmodule

// File: rtl/fault_alert_agg.sv
module fault_alert_agg
  import fault_alert_pkg::*;
#(
  parameter  int NCH  = 2,
  localparam int PG_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CHW  = NCH * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHW-1:0]    ch_ev_vout,
  input  logic [CHW-1:0]    ch_ev_iout,
  input  logic [CHW-1:0]    ch_ev_temp,
  input  logic [BYTE_W-1:0] in_ev,
  input  logic [BYTE_W-1:0] comm_ev,
  input  logic [NCH-1:0]    ch_pwr_on,
  input  logic              clr_all,
  input  logic              reg_wr,
  input  logic [PG_W-1:0]   reg_page,
  input  logic [3:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              alert_n
);
  localparam int FLAT_W = 3 * CHW + 2 * BYTE_W;

  logic rst_q_n;
  logic st_wr, mk_wr;
  logic [2:0] cat;
  logic [CHW-1:0] vout_st, iout_st, temp_st, vout_mk, iout_mk, temp_mk;
  logic [CHW-1:0] sum_b, sum_w;
  logic [BYTE_W-1:0] input_st, input_mk, comm_st, comm_mk;
  logic [FLAT_W-1:0] stat_flat, mask_flat;

  fab_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  assign cat   = reg_addr[2:0];
  assign st_wr = reg_wr & ~reg_addr[3];
  assign mk_wr = reg_wr &  reg_addr[3];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel = (int'(reg_page) == c);

    fab_sticky_byte #(.W(BYTE_W), .SUPPORTED(SUP_VOUT)) u_vout (
      .clk(clk), .rst_n(rst_q_n), .evt(ch_ev_vout[c*BYTE_W +: BYTE_W]),
      .clr_we(st_wr && sel && cat == CAT_VOUT), .clr_bits(reg_wdata), .clr_all(clr_all),
      .mask_we(mk_wr && sel && cat == CAT_VOUT), .mask_wdata(reg_wdata),
      .stat(vout_st[c*BYTE_W +: BYTE_W]), .mask(vout_mk[c*BYTE_W +: BYTE_W]));

    fab_sticky_byte #(.W(BYTE_W), .SUPPORTED(SUP_IOUT)) u_iout (
      .clk(clk), .rst_n(rst_q_n), .evt(ch_ev_iout[c*BYTE_W +: BYTE_W]),
      .clr_we(st_wr && sel && cat == CAT_IOUT), .clr_bits(reg_wdata), .clr_all(clr_all),
      .mask_we(mk_wr && sel && cat == CAT_IOUT), .mask_wdata(reg_wdata),
      .stat(iout_st[c*BYTE_W +: BYTE_W]), .mask(iout_mk[c*BYTE_W +: BYTE_W]));

    fab_sticky_byte #(.W(BYTE_W), .SUPPORTED(SUP_TEMP)) u_temp (
      .clk(clk), .rst_n(rst_q_n), .evt(ch_ev_temp[c*BYTE_W +: BYTE_W]),
      .clr_we(st_wr && sel && cat == CAT_TEMP), .clr_bits(reg_wdata), .clr_all(clr_all),
      .mask_we(mk_wr && sel && cat == CAT_TEMP), .mask_wdata(reg_wdata),
      .stat(temp_st[c*BYTE_W +: BYTE_W]), .mask(temp_mk[c*BYTE_W +: BYTE_W]));

    fab_summary u_sum (
      .vout_st(vout_st[c*BYTE_W +: BYTE_W]), .iout_st(iout_st[c*BYTE_W +: BYTE_W]),
      .temp_st(temp_st[c*BYTE_W +: BYTE_W]), .input_st(input_st), .comm_st(comm_st),
      .pwr_on(ch_pwr_on[c]),
      .sum_byte(sum_b[c*BYTE_W +: BYTE_W]), .sum_word_hi(sum_w[c*BYTE_W +: BYTE_W]));
  end

  fab_sticky_byte #(.W(BYTE_W), .SUPPORTED(SUP_INPUT)) u_input (
    .clk(clk), .rst_n(rst_q_n), .evt(in_ev),
    .clr_we(st_wr && cat == CAT_INPUT), .clr_bits(reg_wdata), .clr_all(clr_all),
    .mask_we(mk_wr && cat == CAT_INPUT), .mask_wdata(reg_wdata),
    .stat(input_st), .mask(input_mk));

  fab_sticky_byte #(.W(BYTE_W), .SUPPORTED(SUP_COMM)) u_comm (
    .clk(clk), .rst_n(rst_q_n), .evt(comm_ev),
    .clr_we(st_wr && cat == CAT_COMM), .clr_bits(reg_wdata), .clr_all(clr_all),
    .mask_we(mk_wr && cat == CAT_COMM), .mask_wdata(reg_wdata),
    .stat(comm_st), .mask(comm_mk));

  assign stat_flat = {comm_st, input_st, temp_st, iout_st, vout_st};
  assign mask_flat = {comm_mk, input_mk, temp_mk, iout_mk, vout_mk};

  // alert is driven from registered state only
  assign alert_n = ~|(stat_flat & ~mask_flat);

  always_comb begin
    int pg;
    pg        = int'(reg_page);
    reg_rdata = '0;
    if (pg < NCH) begin
      case (reg_addr)
        4'h0:    reg_rdata = sum_b[pg*BYTE_W +: BYTE_W];
        4'h1:    reg_rdata = sum_w[pg*BYTE_W +: BYTE_W];
        4'h2:    reg_rdata = vout_st[pg*BYTE_W +: BYTE_W];
        4'h3:    reg_rdata = iout_st[pg*BYTE_W +: BYTE_W];
        4'h4:    reg_rdata = input_st;
        4'h5:    reg_rdata = temp_st[pg*BYTE_W +: BYTE_W];
        4'h6:    reg_rdata = comm_st;
        4'hA:    reg_rdata = vout_mk[pg*BYTE_W +: BYTE_W];
        4'hB:    reg_rdata = iout_mk[pg*BYTE_W +: BYTE_W];
        4'hC:    reg_rdata = input_mk;
        4'hD:    reg_rdata = temp_mk[pg*BYTE_W +: BYTE_W];
        4'hE:    reg_rdata = comm_mk;
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fault_alert_agg_chk.sv
module fault_alert_agg_chk
  import fault_alert_pkg::*;
#(
  parameter  int NCH    = 2,
  localparam int FLAT_W = 3 * NCH * BYTE_W + 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FLAT_W-1:0] ev_all,
  input logic [FLAT_W-1:0] stat_all,
  input logic              reg_wr,
  input logic              clr_all,
  input logic              alert_n
);
  localparam logic [FLAT_W-1:0] SUP_ALL =
    {SUP_COMM, SUP_INPUT, {NCH{SUP_TEMP}}, {NCH{SUP_IOUT}}, {NCH{SUP_VOUT}}};

  logic [FLAT_W-1:0] ev_sup;
  assign ev_sup = ev_all & SUP_ALL;

  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_sup) |=> ((stat_all & $past(ev_sup)) == $past(ev_sup))); // R11

  AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !clr_all) |=> ((stat_all & $past(stat_all)) == $past(stat_all))); // R3

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && ev_sup == '0) |=> (stat_all == '0)); // R5

  AST_UNSUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_all & ~SUP_ALL) == '0)); // R10

  AST_ALERT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_n && !reg_wr && !clr_all) |=> !alert_n); // R2
endmodule

bind fault_alert_agg fault_alert_agg_chk #(.NCH(NCH)) u_chk (
  .clk(clk),
  .rst_n(rst_q_n),
  .ev_all({comm_ev, in_ev, ch_ev_temp, ch_ev_iout, ch_ev_vout}),
  .stat_all(stat_flat),
  .reg_wr(reg_wr),
  .clr_all(clr_all),
  .alert_n(alert_n)
);

// File: tb/fault_alert_agg_test.sv
module fault_alert_agg_test;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ch_ev_vout, ch_ev_iout, ch_ev_temp;
  logic [7:0]  in_ev, comm_ev;
  logic [1:0]  ch_pwr_on;
  logic        clr_all, reg_wr;
  logic [0:0]  reg_page;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        alert_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fault_alert_agg #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .ch_ev_vout(ch_ev_vout), .ch_ev_iout(ch_ev_iout),
    .ch_ev_temp(ch_ev_temp), .in_ev(in_ev), .comm_ev(comm_ev), .ch_pwr_on(ch_pwr_on),
    .clr_all(clr_all), .reg_wr(reg_wr), .reg_page(reg_page), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alert_n(alert_n));

  // kind codes for the vector table
  localparam logic [3:0] K_EVT = 4'd1, K_WR = 4'd2, K_RD = 4'd3, K_ALR = 4'd4, K_CLR = 4'd5;

  // {kind, page, addr, requirement, data, expected}
  localparam int NV = 31;
  localparam logic [31:0] VEC [NV] = '{
    {K_RD,  4'd0, 4'h2, 4'd1,  8'h00, 8'h00},  // R1 empty
    {K_EVT, 4'd0, 4'h2, 4'd1,  8'h80, 8'h00},  // R1 vout over-fault ch0
    {K_RD,  4'd0, 4'h2, 4'd1,  8'h00, 8'h80},  // R1
    {K_RD,  4'd1, 4'h2, 4'd12, 8'h00, 8'h00},  // R12 other channel clean
    {K_ALR, 4'd0, 4'h0, 4'd2,  8'h00, 8'h00},  // R2 alert low
    {K_RD,  4'd0, 4'h0, 4'd7,  8'h00, 8'h20},  // R7
    {K_RD,  4'd0, 4'h1, 4'd8,  8'h00, 8'h80},  // R8
    {K_WR,  4'd0, 4'h2, 4'd4,  8'h40, 8'h00},  // R4 clear an unset bit
    {K_RD,  4'd0, 4'h2, 4'd4,  8'h00, 8'h80},  // R4 untouched
    {K_WR,  4'd0, 4'h2, 4'd4,  8'h80, 8'h00},  // R4 clear it
    {K_RD,  4'd0, 4'h2, 4'd4,  8'h00, 8'h00},  // R4
    {K_ALR, 4'd0, 4'h0, 4'd2,  8'h00, 8'h01},  // R2 released
    {K_EVT, 4'd1, 4'h5, 4'd1,  8'h40, 8'h00},  // R1 temp over-warn ch1
    {K_RD,  4'd1, 4'h5, 4'd1,  8'h00, 8'h40},  // R1
    {K_RD,  4'd1, 4'h0, 4'd7,  8'h00, 8'h04},  // R7 temp summary
    {K_ALR, 4'd0, 4'h0, 4'd2,  8'h00, 8'h00},  // R2
    {K_WR,  4'd0, 4'h5, 4'd12, 8'h40, 8'h00},  // R12 write on wrong page
    {K_RD,  4'd1, 4'h5, 4'd12, 8'h00, 8'h40},  // R12 still set
    {K_WR,  4'd1, 4'h5, 4'd4,  8'hFF, 8'h00},  // R4
    {K_RD,  4'd1, 4'h5, 4'd4,  8'h00, 8'h00},  // R4
    {K_EVT, 4'd0, 4'h4, 4'd10, 8'hFF, 8'h00},  // R10 all input events
    {K_RD,  4'd1, 4'h4, 4'd10, 8'h00, 8'hB0},  // R10 R12 shared, unsupported 0
    {K_RD,  4'd0, 4'h1, 4'd8,  8'h00, 8'h20},  // R8
    {K_RD,  4'd0, 4'h0, 4'd7,  8'h00, 8'h08},  // R7
    {K_CLR, 4'd0, 4'h0, 4'd5,  8'h00, 8'h00},  // R5
    {K_RD,  4'd0, 4'h4, 4'd5,  8'h00, 8'h00},  // R5
    {K_EVT, 4'd0, 4'h6, 4'd7,  8'h01, 8'h00},  // R7 busy
    {K_RD,  4'd0, 4'h0, 4'd7,  8'h00, 8'h80},  // R7
    {K_RD,  4'd1, 4'h6, 4'd1,  8'h00, 8'h01},  // R1
    {K_CLR, 4'd0, 4'h0, 4'd5,  8'h00, 8'h00},  // R5
    {K_ALR, 4'd0, 4'h0, 4'd5,  8'h00, 8'h01}   // R5
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input int req, input string what, input logic [7:0] got,
                       input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic put_event(input logic [3:0] page, input logic [3:0] addr,
                           input logic [7:0] bits);
    case (addr)
      4'h2: ch_ev_vout[page[0]*8 +: 8] = bits;
      4'h3: ch_ev_iout[page[0]*8 +: 8] = bits;
      4'h5: ch_ev_temp[page[0]*8 +: 8] = bits;
      4'h4: in_ev = bits;
      4'h6: comm_ev = bits;
      default: ;
    endcase
  endtask

  task automatic idle_inputs();
    ch_ev_vout = '0; ch_ev_iout = '0; ch_ev_temp = '0;
    in_ev = '0; comm_ev = '0; clr_all = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic do_event(input logic [3:0] page, input logic [3:0] addr,
                          input logic [7:0] bits);
    put_event(page, addr, bits);
    tick();
    idle_inputs();
  endtask

  task automatic do_write(input logic [3:0] page, input logic [3:0] addr,
                          input logic [7:0] data);
    reg_wr = 1'b1; reg_page = page[0]; reg_addr = addr; reg_wdata = data;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input int req, input logic [3:0] page, input logic [3:0] addr,
                         input logic [7:0] exp);
    reg_page = page[0]; reg_addr = addr;
    #1;
    check(req, $sformatf("read page %0d addr %h", page, addr), reg_rdata, exp);
  endtask

  task automatic do_clear();
    clr_all = 1'b1;
    tick();
    clr_all = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    ch_pwr_on = 2'b00; reg_page = '0; reg_addr = '0; reg_wdata = '0;
    #1;
    check(2, "alert in reset", {7'b0, alert_n}, 8'h01);  // R2
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();

    // reset state: sticky bits clear, off bit live while unpowered
    do_read(1, 4'd0, 4'h2, 8'h00);   // R1
    do_read(9, 4'd0, 4'h0, 8'h40);   // R9
    check(9, "alert with off bit", {7'b0, alert_n}, 8'h01);  // R9
    ch_pwr_on = 2'b11;
    do_read(9, 4'd0, 4'h0, 8'h00);   // R9

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [3:0] kind, page, addr, req;
      logic [7:0] data, exp;
      {kind, page, addr, req, data, exp} = VEC[i];
      case (kind)
        K_EVT: do_event(page, addr, data);
        K_WR:  do_write(page, addr, data);
        K_RD:  do_read(int'(req), page, addr, exp);
        K_ALR: check(int'(req), "alert level", {7'b0, alert_n}, exp);
        K_CLR: do_clear();
        default: ;
      endcase
    end

    // masking: latch without alert
    do_write(4'd0, 4'hA, 8'h80);
    do_event(4'd0, 4'h2, 8'h80);
    do_read(6, 4'd0, 4'h2, 8'h80);                         // R6
    check(6, "masked alert", {7'b0, alert_n}, 8'h01);      // R6
    do_event(4'd0, 4'h3, 8'h80);
    check(2, "unmasked alert", {7'b0, alert_n}, 8'h00);    // R2
    do_write(4'd0, 4'h3, 8'h80);
    check(6, "only masked left", {7'b0, alert_n}, 8'h01);  // R6
    do_read(6, 4'd0, 4'h2, 8'h80);                         // R6
    do_clear();
    do_read(5, 4'd0, 4'hA, 8'h80);                         // R5 mask kept
    do_read(5, 4'd0, 4'h2, 8'h00);                         // R5
    do_write(4'd0, 4'hA, 8'h00);

    // unsupported mask bits
    do_write(4'd1, 4'hB, 8'hFF);
    do_read(10, 4'd1, 4'hB, 8'hA0);                        // R10
    do_read(10, 4'd0, 4'h7, 8'h00);                        // R10
    do_write(4'd1, 4'hB, 8'h00);

    // collision: event with write-one-to-clear on the same bit
    do_event(4'd0, 4'h5, 8'h10);
    ch_ev_temp[7:0] = 8'h10;
    reg_wr = 1'b1; reg_page = 1'b0; reg_addr = 4'h5; reg_wdata = 8'h10;
    tick();
    idle_inputs();
    do_read(11, 4'd0, 4'h5, 8'h10);                        // R11

    // collision: event with clear-all
    ch_ev_temp[7:0] = 8'h20;
    clr_all = 1'b1;
    tick();
    idle_inputs();
    do_read(11, 4'd0, 4'h5, 8'h20);                        // R11
    check(11, "alert after collision", {7'b0, alert_n}, 8'h00);  // R11

    // held event does not stop a clear from ending the alert later
    do_clear();
    check(3, "alert after clear", {7'b0, alert_n}, 8'h01); // R3

    // off bit tracks power live
    ch_pwr_on = 2'b10;
    do_read(9, 4'd0, 4'h0, 8'h40);                         // R9
    do_read(9, 4'd1, 4'h0, 8'h00);                         // R9
    ch_pwr_on = 2'b11;
    do_read(9, 4'd0, 4'h0, 8'h00);                         // R9

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule